// File: doc/BRIEF.md
# Oscillator Capacitor-Trim Calibration Controller

This controller finds a 7-bit capacitor trim code for an oscillator by binary search. It does not take the last code it tried. It keeps the code whose measured ADC level came closest to a fixed target. It has no bus of its own. It issues single-cycle register writes and register reads, and a surrounding bus bridge turns these into real transfers. After a start pulse it runs this sequence:

1. Three setup writes.
2. A long settle wait.
3. Seven iterations. In each one it writes a trim code, waits a shorter settle time, reads the ADC and moves the code up or down by a shrinking step.
4. It programs the best code, writes a closing value to the gate register and pulses done.

The states are `ST_IDLE`, `ST_SETUP`, `ST_WAIT_SETUP`, `ST_TRIM_WR`, `ST_WAIT_SAMPLE`, `ST_MEAS_RD`, `ST_EVAL`, `ST_FINAL_TRIM`, `ST_FINAL_GATE` and `ST_REPORT`. The transitions are:

- `ST_IDLE` goes to `ST_SETUP` on an accepted start.
- `ST_SETUP` goes to `ST_WAIT_SETUP` after its third write.
- `ST_WAIT_SETUP` goes to `ST_TRIM_WR` when its timer expires.
- `ST_TRIM_WR` goes to `ST_WAIT_SAMPLE`.
- `ST_WAIT_SAMPLE` goes to `ST_MEAS_RD` when its timer expires.
- `ST_MEAS_RD` goes to `ST_EVAL`.
- `ST_EVAL` goes back to `ST_TRIM_WR` while the step is nonzero. Otherwise it goes to `ST_FINAL_TRIM`.
- `ST_FINAL_TRIM` goes to `ST_FINAL_GATE`, then to `ST_REPORT`, then back to `ST_IDLE`.

Settle times are given in units of 0.1 ms. The length of one unit in clock cycles is set by the `TICKS_PER_UNIT` parameter.

Top module: `trim_cal_ctrl`

## Requirements
- R1: After reset the block is idle: busy_o, done_o, wr_en_o and rd_en_o are low, and best_code_o is 64.
- R2: A start_i high at a clock edge while idle is accepted. In the next three cycles the block issues one write per cycle: address 0x0f with 0xed10, then 0x17 with 0x0034, then 0x18 with 0x0032.
- R3: After the setup writes, exactly SETUP_UNITS×TICKS_PER_UNIT cycles pass with no write or read. Then the first trim write follows.
- R4: Each iteration is laid out as follows:
  - a single write to address 0x14;
  - exactly SAMPLE_UNITS×TICKS_PER_UNIT quiet cycles;
  - a single read request to address 0x19;
  - one quiet evaluation cycle, at whose end rd_data_i is taken.
- R5: The trim write carries upper_i OR the current code. The code starts at 64 and the step starts at 64. The step is halved before each trim write. The block runs seven iterations, with steps 32, 16, 8, 4, 2, 1 and 0. After a sample at or above 400 the code drops by the step; below 400 it rises by the step.
- R6: The error is |sample−400|. The best error starts at 3000 and the best code starts at 64. Only an error strictly smaller than the best error replaces the best code, so on a tie the earlier code stays. best_code_o shows the update from the cycle after the evaluation.
- R7: After the last evaluation the block writes upper_i OR the best code to 0x14, then 0x07ff to 0x18, and then raises done_o for exactly one cycle.
- R8: start_i is ignored while busy. The running sequence is unchanged and produces one done pulse.
- R9: best_code_o holds its value while idle and returns to 64 in the cycle after an accepted start.
- R10: busy_o is high from the first setup write through the done cycle, and low otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start request, taken while idle |
| upper_i | input | 16 | Upper field ORed into every trim write |
| wr_en_o | output | 1 | Register write strobe, one cycle per write |
| wr_addr_o | output | 8 | Write address |
| wr_data_o | output | 16 | Write data |
| rd_en_o | output | 1 | Register read request |
| rd_addr_o | output | 8 | Read address (0x19 when requested) |
| rd_data_i | input | 10 | ADC result, valid in the cycle after rd_en_o |
| busy_o | output | 1 | Calibration in progress |
| done_o | output | 1 | One-cycle completion pulse |
| best_code_o | output | 7 | Best trim code found so far / last result |

## Verification
The bench builds the block with TICKS_PER_UNIT=2, which gives a 40-cycle setup wait and a 30-cycle sample wait. A full calibration therefore lasts about 280 cycles, so several complete runs fit in one simulation. The exact quiet-window lengths are still checked cycle by cycle, since a two-tick unit exposes any off-by-one in the timer load. The ADC model is linear in the code with a selectable slope and offset. Runs include an exact hit on the target, constant readings that drive the code to both ends (1 and 127) with tied errors, and a start pulse in the middle of a run.

// File: rtl/tcal_pkg.sv
package tcal_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 16;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_WAIT_SETUP,
        ST_TRIM_WR,
        ST_WAIT_SAMPLE,
        ST_MEAS_RD,
        ST_EVAL,
        ST_FINAL_TRIM,
        ST_FINAL_GATE,
        ST_REPORT
    } tcal_state_e;

    // register addresses used by the sequence
    localparam logic [ADDR_W-1:0] ADDR_BIAS = 8'h0f;
    localparam logic [ADDR_W-1:0] ADDR_MODE = 8'h17;
    localparam logic [ADDR_W-1:0] ADDR_GATE = 8'h18;
    localparam logic [ADDR_W-1:0] ADDR_TRIM = 8'h14;
    localparam logic [ADDR_W-1:0] ADDR_MEAS = 8'h19;

    // fixed values written during setup and at the end
    localparam logic [DATA_W-1:0] VAL_BIAS     = 16'hed10;
    localparam logic [DATA_W-1:0] VAL_MODE     = 16'h0034;
    localparam logic [DATA_W-1:0] VAL_GATE_CAL = 16'h0032;
    localparam logic [DATA_W-1:0] VAL_GATE_RUN = 16'h07ff;

endpackage

// File: rtl/tcal_settle_timer.sv
module tcal_settle_timer #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             zero_o
);

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load_i) begin
            cnt_q <= load_val_i;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero_o = (cnt_q == '0);

endmodule

// File: rtl/tcal_err_eval.sv
module tcal_err_eval #(
    parameter int ADC_W  = 10,
    parameter int ERR_W  = 12,
    parameter int TARGET = 400
) (
    input  logic [ADC_W-1:0] sample_i,
    output logic [ERR_W-1:0] err_o,
    output logic             go_down_o
);

    localparam logic [ERR_W-1:0] TGT = ERR_W'(TARGET);

    logic [ERR_W-1:0] sample_ext;

    always_comb begin
        sample_ext = ERR_W'(sample_i);
        if (sample_ext >= TGT) begin
            go_down_o = 1'b1;
            err_o     = sample_ext - TGT;
        end else begin
            go_down_o = 1'b0;
            err_o     = TGT - sample_ext;
        end
    end

endmodule

// File: rtl/trim_cal_ctrl.sv
module trim_cal_ctrl
    import tcal_pkg::*;
#(
    parameter int CODE_W         = 7,
    parameter int ADC_W          = 10,
    parameter int TICKS_PER_UNIT = 10000,
    parameter int SETUP_UNITS    = 20,
    parameter int SAMPLE_UNITS   = 15,
    parameter int TARGET         = 400,
    parameter int INIT_ERR       = 3000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] upper_i,
    output logic              wr_en_o,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [DATA_W-1:0] wr_data_o,
    output logic              rd_en_o,
    output logic [ADDR_W-1:0] rd_addr_o,
    input  logic [ADC_W-1:0]  rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic [CODE_W-1:0] best_code_o
);

    localparam int SETUP_CYC  = SETUP_UNITS * TICKS_PER_UNIT;
    localparam int SAMPLE_CYC = SAMPLE_UNITS * TICKS_PER_UNIT;
    localparam int MAX_CYC    = (SETUP_CYC > SAMPLE_CYC) ? SETUP_CYC : SAMPLE_CYC;
    localparam int CNT_W      = $clog2(MAX_CYC + 1);
    localparam int ERR_A      = $clog2(INIT_ERR + 1);
    localparam int ERR_B      = $clog2(TARGET + 1);
    localparam int ERR_AB     = (ERR_A > ERR_B) ? ERR_A : ERR_B;
    localparam int ERR_W      = (ERR_AB > ADC_W) ? ERR_AB : ADC_W;

    localparam logic [CODE_W-1:0] CODE_MID   = CODE_W'(1) << (CODE_W - 1);
    localparam logic [ERR_W-1:0]  ERR_START  = ERR_W'(INIT_ERR);
    localparam logic [CNT_W-1:0]  SETUP_LOAD = CNT_W'(SETUP_CYC - 1);
    localparam logic [CNT_W-1:0]  SAMP_LOAD  = CNT_W'(SAMPLE_CYC - 1);

    tcal_state_e       state_q, state_d;
    logic [1:0]        setup_idx_q;
    logic [CODE_W-1:0] step_q;
    logic [CODE_W-1:0] code_q;
    logic [CODE_W-1:0] best_q;
    logic [ERR_W-1:0]  berr_q;

    logic              tmr_load;
    logic [CNT_W-1:0]  tmr_val;
    logic              tmr_zero;
    logic [ERR_W-1:0]  meas_err;
    logic              meas_down;

    tcal_settle_timer #(
        .CNT_W(CNT_W)
    ) u_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (tmr_load),
        .load_val_i (tmr_val),
        .zero_o     (tmr_zero)
    );

    tcal_err_eval #(
        .ADC_W  (ADC_W),
        .ERR_W  (ERR_W),
        .TARGET (TARGET)
    ) u_eval (
        .sample_i  (rd_data_i),
        .err_o     (meas_err),
        .go_down_o (meas_down)
    );

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:        if (start_i) state_d = ST_SETUP;
            ST_SETUP:       if (setup_idx_q == 2'd2) state_d = ST_WAIT_SETUP;
            ST_WAIT_SETUP:  if (tmr_zero) state_d = ST_TRIM_WR;
            ST_TRIM_WR:     state_d = ST_WAIT_SAMPLE;
            ST_WAIT_SAMPLE: if (tmr_zero) state_d = ST_MEAS_RD;
            ST_MEAS_RD:     state_d = ST_EVAL;
            ST_EVAL:        state_d = (step_q != '0) ? ST_TRIM_WR : ST_FINAL_TRIM;
            ST_FINAL_TRIM:  state_d = ST_FINAL_GATE;
            ST_FINAL_GATE:  state_d = ST_REPORT;
            ST_REPORT:      state_d = ST_IDLE;
            default:        state_d = ST_IDLE;
        endcase
    end

    // search datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            setup_idx_q <= 2'd0;
            step_q      <= CODE_MID;
            code_q      <= CODE_MID;
            best_q      <= CODE_MID;
            berr_q      <= ERR_START;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        setup_idx_q <= 2'd0;
                        step_q      <= CODE_MID;
                        code_q      <= CODE_MID;
                        best_q      <= CODE_MID;
                        berr_q      <= ERR_START;
                    end
                end
                ST_SETUP:   setup_idx_q <= setup_idx_q + 2'd1;
                ST_TRIM_WR: step_q <= step_q >> 1;
                ST_EVAL: begin
                    if (meas_err < berr_q) begin
                        berr_q <= meas_err;
                        best_q <= code_q;
                    end
                    code_q <= meas_down ? (code_q - step_q) : (code_q + step_q);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        wr_en_o   = 1'b0;
        wr_addr_o = '0;
        wr_data_o = '0;
        rd_en_o   = 1'b0;
        rd_addr_o = '0;
        done_o    = 1'b0;
        busy_o    = (state_q != ST_IDLE);
        tmr_load  = 1'b0;
        tmr_val   = '0;
        unique case (state_q)
            ST_SETUP: begin
                wr_en_o = 1'b1;
                unique case (setup_idx_q)
                    2'd0: begin wr_addr_o = ADDR_BIAS; wr_data_o = VAL_BIAS; end
                    2'd1: begin wr_addr_o = ADDR_MODE; wr_data_o = VAL_MODE; end
                    default: begin
                        wr_addr_o = ADDR_GATE;
                        wr_data_o = VAL_GATE_CAL;
                        tmr_load  = 1'b1;
                        tmr_val   = SETUP_LOAD;
                    end
                endcase
            end
            ST_TRIM_WR: begin
                wr_en_o   = 1'b1;
                wr_addr_o = ADDR_TRIM;
                wr_data_o = upper_i | DATA_W'(code_q);
                tmr_load  = 1'b1;
                tmr_val   = SAMP_LOAD;
            end
            ST_MEAS_RD: begin
                rd_en_o   = 1'b1;
                rd_addr_o = ADDR_MEAS;
            end
            ST_FINAL_TRIM: begin
                wr_en_o   = 1'b1;
                wr_addr_o = ADDR_TRIM;
                wr_data_o = upper_i | DATA_W'(best_q);
            end
            ST_FINAL_GATE: begin
                wr_en_o   = 1'b1;
                wr_addr_o = ADDR_GATE;
                wr_data_o = VAL_GATE_RUN;
            end
            ST_REPORT: done_o = 1'b1;
            default: ;
        endcase
    end

    assign best_code_o = best_q;

endmodule

// File: rtl/trim_cal_ctrl_chk.sv
module trim_cal_ctrl_chk
    import tcal_pkg::*;
#(
    parameter int CODE_W = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_o,
    input logic [ADDR_W-1:0] wr_addr_o,
    input logic              rd_en_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [CODE_W-1:0] best_code_o
);

    // R7
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_after_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(wr_en_o) && $past(wr_addr_o) == ADDR_GATE));

    // R4
    port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en_o && rd_en_o));

    // R4
    eval_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en_o |=> (!rd_en_o && !wr_en_o));

    // R2
    first_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> (wr_en_o && wr_addr_o == ADDR_BIAS));

    // R9
    best_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !$past(busy_o)) |-> $stable(best_code_o));

    // R10
    wr_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o || rd_en_o || done_o) |-> busy_o);

endmodule

bind trim_cal_ctrl trim_cal_ctrl_chk #(.CODE_W(CODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en_o     (wr_en_o),
    .wr_addr_o   (wr_addr_o),
    .rd_en_o     (rd_en_o),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .best_code_o (best_code_o)
);

// File: tb/trim_cal_ctrl_tb_top.sv
module trim_cal_ctrl_tb_top;

    localparam int TICKS    = 2;
    localparam int SET_U    = 20;
    localparam int SAM_U    = 15;
    localparam int SET_CYC  = TICKS * SET_U;
    localparam int SAM_CYC  = TICKS * SAM_U;

    typedef struct {
        bit    wr;
        int    addr;
        int    data;
        bit    rd;
        bit    done;
        int    best;
        string tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] upper_i = 16'h0;
    logic        wr_en_o, rd_en_o, busy_o, done_o;
    logic [7:0]  wr_addr_o, rd_addr_o;
    logic [15:0] wr_data_o;
    logic [9:0]  rd_data_i = 10'd0;
    logic [6:0]  best_code_o;

    int   n_cmp = 0;
    int   n_bad = 0;
    bit   chk_en = 1'b0;
    int   held_best = 64;
    int   r_slope = 0;
    int   r_off = 0;
    int   done_cnt = 0;
    logic [15:0] reg_trim = 16'h0;
    exp_t q[$];

    always #5 clk = ~clk;

    trim_cal_ctrl #(
        .TICKS_PER_UNIT (TICKS),
        .SETUP_UNITS    (SET_U),
        .SAMPLE_UNITS   (SAM_U)
    ) dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .upper_i     (upper_i),
        .wr_en_o     (wr_en_o),
        .wr_addr_o   (wr_addr_o),
        .wr_data_o   (wr_data_o),
        .rd_en_o     (rd_en_o),
        .rd_addr_o   (rd_addr_o),
        .rd_data_i   (rd_data_i),
        .busy_o      (busy_o),
        .done_o      (done_o),
        .best_code_o (best_code_o)
    );

    function automatic int resp(int code);
        int v;
        v = r_slope * code + r_off;
        if (v < 0) v = 0;
        if (v > 1023) v = 1023;
        return v;
    endfunction

    // register-file model of the oscillator and ADC
    always @(posedge clk) begin
        if (wr_en_o && wr_addr_o == 8'h14) reg_trim <= wr_data_o;
        if (rd_en_o) rd_data_i <= 10'(resp(int'(reg_trim[6:0])));
    end

    task automatic push(bit wr, int a, int d, bit rd, bit dn, int best, string tag);
        exp_t e;
        e.wr = wr; e.addr = a; e.data = d; e.rd = rd; e.done = dn; e.best = best; e.tag = tag;
        q.push_back(e);
    endtask

    // behavioural reference: builds the whole expected cycle trace of one run
    task automatic build(int upper, output int final_best);
        int step, code, best, berr, adc, err;
        bit dn;
        step = 64; code = 64; best = 64; berr = 3000;
        push(1, 'h0f, 'hed10, 0, 0, best, "R2");
        push(1, 'h17, 'h0034, 0, 0, best, "R2");
        push(1, 'h18, 'h0032, 0, 0, best, "R2");
        for (int i = 0; i < SET_CYC; i++) push(0, 0, 0, 0, 0, best, "R3");
        do begin
            step = step / 2;
            push(1, 'h14, upper | code, 0, 0, best, "R5");
            for (int i = 0; i < SAM_CYC; i++) push(0, 0, 0, 0, 0, best, "R4");
            push(0, 0, 0, 1, 0, best, "R4");
            push(0, 0, 0, 0, 0, best, "R6");
            adc = resp(code);
            dn  = (adc >= 400);
            err = dn ? adc - 400 : 400 - adc;
            if (err < berr) begin
                berr = err;
                best = code;
            end
            code = dn ? code - step : code + step;
        end while (step >= 1);
        push(1, 'h14, upper | best, 0, 0, best, "R7");
        push(1, 'h18, 'h07ff, 0, 0, best, "R7");
        push(0, 0, 0, 0, 1, best, "R7");
        final_best = best;
    endtask

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        if (chk_en) begin
            exp_t e;
            bit   busy_e;
            bit   bad;
            if (q.size() != 0) begin
                e = q.pop_front();
                busy_e = 1'b1;
            end else begin
                e.wr = 0; e.addr = 0; e.data = 0; e.rd = 0; e.done = 0;
                e.best = held_best; e.tag = "R9";
                busy_e = 1'b0;
            end
            bad = 1'b0;
            n_cmp++;
            if (wr_en_o !== e.wr) begin
                bad = 1'b1;
                $display("FAIL %s wr_en act=%0b exp=%0b t=%0t", e.tag, wr_en_o, e.wr, $time);
            end else if (e.wr && (int'(wr_addr_o) != e.addr || int'(wr_data_o) != e.data)) begin
                bad = 1'b1;
                $display("FAIL %s write act=%h:%h exp=%h:%h t=%0t", e.tag, wr_addr_o, wr_data_o,
                         e.addr[7:0], e.data[15:0], $time);
            end
            if (rd_en_o !== e.rd) begin
                bad = 1'b1;
                $display("FAIL %s rd_en act=%0b exp=%0b t=%0t", e.tag, rd_en_o, e.rd, $time);
            end else if (e.rd && rd_addr_o !== 8'h19) begin
                bad = 1'b1;
                $display("FAIL R4 rd_addr act=%h exp=19 t=%0t", rd_addr_o, $time);
            end
            if (done_o !== e.done) begin
                bad = 1'b1;
                $display("FAIL %s done act=%0b exp=%0b t=%0t", e.tag, done_o, e.done, $time);
            end
            if (busy_o !== busy_e) begin
                bad = 1'b1;
                $display("FAIL R10 busy act=%0b exp=%0b t=%0t", busy_o, busy_e, $time);
            end
            if (int'(best_code_o) != e.best) begin
                bad = 1'b1;
                $display("FAIL %s best act=%0d exp=%0d t=%0t", e.tag, best_code_o, e.best, $time);
            end
            if (bad) n_bad++;
            if (done_o) done_cnt++;
        end
    end

    task automatic check_val(string tag, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
        end
    endtask

    task automatic run_cal(int upper, int slope, int off, int mid_start, int exp_best);
        int fb;
        @(negedge clk);
        #1;
        upper_i = 16'(upper);
        r_slope = slope;
        r_off   = off;
        done_cnt = 0;
        build(upper, fb);
        start_i = 1'b1;
        @(negedge clk);
        #1;
        start_i = 1'b0;
        if (mid_start > 0) begin
            repeat (mid_start) @(negedge clk);
            #1;
            start_i = 1'b1;   // R8: must be ignored
            @(negedge clk);
            #1;
            start_i = 1'b0;
        end
        while (q.size() != 0) @(negedge clk);
        held_best = fb;
        repeat (6) @(negedge clk);
        check_val("R7 done count", done_cnt, 1);
        if (exp_best >= 0) check_val("R6 final best", int'(best_code_o), exp_best);
        check_val("R9 held best", int'(best_code_o), fb);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        check_val("R1 busy", int'(busy_o), 0);
        check_val("R1 best", int'(best_code_o), 64);
        chk_en = 1'b1;
        repeat (4) @(negedge clk);
        // R6: exact hit at code 80 (adc = 4*code + 80)
        run_cal('h5880, 4, 80, 0, 80);
        // R5: readings always high, code walks down to 1, ties keep 64
        run_cal('h0880, 0, 1023, 0, 64);
        // R5: readings always low, code walks up to 127, ties keep 64
        run_cal('h4000, 0, 0, 0, 64);
        // R8: start pulsed mid-run is ignored
        run_cal('h2400, 6, 10, 100, -1);
        // general slope, falling response
        run_cal('h0000, -5, 900, 0, -1);
        chk_en = 1'b0;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule